// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel of a general-purpose timer, working in output mode. Each clock cycle it compares the value of an external up-counter with an active compare register. From that comparison and a 3-bit behaviour code it produces a registered reference level, `oc_ref`. Later stages (polarity, dead time, pad) take this level as their input. The counter, input capture, dead-time insertion and the polarity stage are outside this block.

Software-facing state is loaded through write strobes: a 2-bit channel role, a configuration word and a compare value. The configuration word holds the behaviour code and the preload, trigger-acceleration and external-clear enables. A compare value either acts at once, or is parked in a preload register until the next update event. Two write locks apply. The role field is frozen while the channel is enabled. The behaviour code and the preload enable are frozen at protection level 3 while the channel is an output. An external clear level can pull the reference low. A trigger pulse can stand in for a compare match.

Top module: `tmr_oc_channel`

## Requirements
- R1: The role field `rd_dir` selects output operation only when it is 2'b00. For 01, 10 or 11, `oc_ref` holds its value whatever the counter, triggers or clear input do.
- R2: A write to the role field (`wr_dir`) takes effect only when `chan_en` is 0. While `chan_en` is 1 the write is ignored and `rd_dir` keeps its value.
- R3: With behaviour code 3'b000 (freeze), `oc_ref` is not changed by compare matches.
- R4: On a match (counter equals active compare value), code 3'b001 sets `oc_ref` to 1, code 3'b010 sets it to 0 and code 3'b011 inverts it. Without a match these codes hold `oc_ref`. `oc_ref` changes on the clock edge that follows the cycle in which the condition is present.
- R5: Code 3'b100 drives `oc_ref` to 0 and code 3'b101 drives it to 1, independent of the counter.
- R6: Code 3'b110 gives `oc_ref` = 1 while counter < compare value, else 0. Code 3'b111 gives `oc_ref` = 1 while counter > compare value, else 0. The level is re-evaluated every cycle, so a change from freeze to a PWM code corrects `oc_ref` on the next edge without a match.
- R7: With the preload enable at 0, a compare write reaches the active compare value (`rd_cmp`) on the next edge.
- R8: With the preload enable at 1, a compare write only loads the preload register. `upd_evt` copies the preload register into the active register. When a write and `upd_evt` fall in the same cycle, the active register takes the preload value held before that write.
- R9: With the clear enable at 1, `ext_clr` high forces `oc_ref` to 0 on the next edge, overriding every code. With the clear enable at 0, `ext_clr` has no effect.
- R10: When `prot_lvl` is 2'b11 and the role is output, a configuration write does not change the behaviour code or the preload enable. The trigger-acceleration and clear enables are still written.
- R11: With the trigger-acceleration enable at 1, a `trig_pulse` acts as a compare match for codes 001, 010 and 011. With it at 0 the pulse has no effect.
- R12: After reset, `oc_ref`, the active and preload compare registers, the role field, the behaviour code and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_val | input | CNT_W | Counter value from the timer |
| upd_evt | input | 1 | Update event pulse |
| trig_pulse | input | 1 | Trigger pulse |
| ext_clr | input | 1 | External clear level |
| chan_en | input | 1 | Channel enable bit |
| prot_lvl | input | 2 | Protection level |
| wr_dir | input | 1 | Role field write strobe |
| dir_wdata | input | 2 | Role field write data |
| wr_cfg | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Behaviour code write data |
| cfg_pre_en | input | 1 | Preload enable write data |
| cfg_fast_en | input | 1 | Trigger-acceleration enable write data |
| cfg_clr_en | input | 1 | External-clear enable write data |
| wr_cmp | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value write data |
| oc_ref | output | 1 | Reference output level |
| rd_dir | output | 2 | Role field readback |
| rd_mode | output | 3 | Behaviour code readback |
| rd_pre_en | output | 1 | Preload enable readback |
| rd_fast_en | output | 1 | Trigger-acceleration enable readback |
| rd_clr_en | output | 1 | External-clear enable readback |
| rd_cmp | output | CNT_W | Active compare value readback |

## Verification
Three pairs of events can coincide. An external clear can arrive in the same cycle as a compare match or a trigger that would set the reference. A compare write can land in the same cycle as an update event while preload is on. A configuration write can meet the protection lock. Directed steps place the clear on a matching counter value in set mode, and a write together with `upd_evt` with a known old preload value. The expected reference is judged to be 0, and the active value to be the old preload. Random stimulus then makes these overlaps often, and a bench model derived from the requirements predicts every output each cycle.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [2:0] {
    OCM_FREEZE = 3'b000,
    OCM_SET    = 3'b001,
    OCM_CLR    = 3'b010,
    OCM_TOG    = 3'b011,
    OCM_LOW    = 3'b100,
    OCM_HIGH   = 3'b101,
    OCM_PWM_LO = 3'b110,
    OCM_PWM_HI = 3'b111
  } oc_mode_e;

  localparam logic [1:0] DIR_OUT  = 2'b00;
  localparam logic [1:0] PROT_TOP = 2'b11;

  typedef struct packed {
    oc_mode_e mode;
    logic     pre_en;
    logic     fast_en;
    logic     clr_en;
  } oc_cfg_t;

endpackage

// File: rtl/oc_cfg_regs.sv
module oc_cfg_regs
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic [1:0] prot_lvl,
  input  logic       wr_dir,
  input  logic [1:0] dir_wdata,
  input  logic       wr_cfg,
  input  oc_cfg_t    cfg_wdata,
  output logic [1:0] dir_q,
  output oc_cfg_t    cfg_q
);

  logic       dir_ce;
  logic       cfg_ce;
  logic       locked;
  logic [1:0] dir_d;
  oc_cfg_t    cfg_d;

  // role field only moves while the channel is disabled
  assign dir_ce = wr_dir & ~chan_en;
  assign cfg_ce = wr_cfg;
  assign locked = (prot_lvl == PROT_TOP) && (dir_q == DIR_OUT);

  always_comb begin
    dir_d = dir_wdata;
    cfg_d = cfg_q;
    cfg_d.fast_en = cfg_wdata.fast_en;
    cfg_d.clr_en  = cfg_wdata.clr_en;
    if (!locked) begin
      cfg_d.mode   = cfg_wdata.mode;
      cfg_d.pre_en = cfg_wdata.pre_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_OUT;
    end else if (dir_ce) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{mode: OCM_FREEZE, pre_en: 1'b0, fast_en: 1'b0, clr_en: 1'b0};
    end else if (cfg_ce) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/oc_cmp_shadow.sv
module oc_cmp_shadow #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_en,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             upd_evt,
  output logic [CNT_W-1:0] cmp_act
);

  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] act_d;
  logic             pre_ce;
  logic             act_ce;

  assign pre_ce = wr_cmp;
  assign act_ce = (pre_en & upd_evt) | (~pre_en & wr_cmp);

  // update transfer uses the preload content held before this cycle's write
  always_comb begin
    act_d = pre_en ? pre_q : cmp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_ce) begin
      pre_q <= cmp_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= '0;
    end else if (act_ce) begin
      cmp_act <= act_d;
    end
  end

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic [1:0]       dir_q,
  input  oc_cfg_t          cfg_q,
  input  logic             trig_pulse,
  input  logic             ext_clr,
  output logic             oc_ref
);

  logic hit;
  logic below;
  logic above;
  logic ref_mode;
  logic ref_d;
  logic ref_ce;

  assign hit   = (cnt_val == cmp_act) | (cfg_q.fast_en & trig_pulse);
  assign below = (cnt_val < cmp_act);
  assign above = (cnt_val > cmp_act);

  always_comb begin
    ref_mode = oc_ref;
    unique case (cfg_q.mode)
      OCM_FREEZE: ref_mode = oc_ref;
      OCM_SET:    ref_mode = hit ? 1'b1 : oc_ref;
      OCM_CLR:    ref_mode = hit ? 1'b0 : oc_ref;
      OCM_TOG:    ref_mode = hit ? ~oc_ref : oc_ref;
      OCM_LOW:    ref_mode = 1'b0;
      OCM_HIGH:   ref_mode = 1'b1;
      OCM_PWM_LO: ref_mode = below;
      OCM_PWM_HI: ref_mode = above;
      default:    ref_mode = oc_ref;
    endcase
  end

  // external clear wins over every behaviour code
  assign ref_d  = (cfg_q.clr_en & ext_clr) ? 1'b0 : ref_mode;
  assign ref_ce = (dir_q == DIR_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_ref <= 1'b0;
    end else if (ref_ce) begin
      oc_ref <= ref_d;
    end
  end

endmodule

// File: rtl/tmr_oc_channel.sv
module tmr_oc_channel
  import oc_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             upd_evt,
  input  logic             trig_pulse,
  input  logic             ext_clr,
  input  logic             chan_en,
  input  logic [1:0]       prot_lvl,
  input  logic             wr_dir,
  input  logic [1:0]       dir_wdata,
  input  logic             wr_cfg,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_pre_en,
  input  logic             cfg_fast_en,
  input  logic             cfg_clr_en,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic             oc_ref,
  output logic [1:0]       rd_dir,
  output logic [2:0]       rd_mode,
  output logic             rd_pre_en,
  output logic             rd_fast_en,
  output logic             rd_clr_en,
  output logic [CNT_W-1:0] rd_cmp
);

  localparam int unsigned SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_pipe;
  logic              rst_n_s;
  oc_cfg_t           cfg_w;
  oc_cfg_t           cfg_q;
  logic [1:0]        dir_q;
  logic [CNT_W-1:0]  cmp_act;

  // asynchronous assert, synchronous release
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_MSB-1:0], 1'b1};
      end
    end
  endgenerate
  assign rst_n_s = rst_pipe[SYNC_MSB];

  assign cfg_w = '{mode:    oc_mode_e'(cfg_mode),
                   pre_en:  cfg_pre_en,
                   fast_en: cfg_fast_en,
                   clr_en:  cfg_clr_en};

  oc_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .chan_en   (chan_en),
    .prot_lvl  (prot_lvl),
    .wr_dir    (wr_dir),
    .dir_wdata (dir_wdata),
    .wr_cfg    (wr_cfg),
    .cfg_wdata (cfg_w),
    .dir_q     (dir_q),
    .cfg_q     (cfg_q)
  );

  oc_cmp_shadow #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .pre_en    (cfg_q.pre_en),
    .wr_cmp    (wr_cmp),
    .cmp_wdata (cmp_wdata),
    .upd_evt   (upd_evt),
    .cmp_act   (cmp_act)
  );

  oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cnt_val    (cnt_val),
    .cmp_act    (cmp_act),
    .dir_q      (dir_q),
    .cfg_q      (cfg_q),
    .trig_pulse (trig_pulse),
    .ext_clr    (ext_clr),
    .oc_ref     (oc_ref)
  );

  assign rd_dir     = dir_q;
  assign rd_mode    = cfg_q.mode;
  assign rd_pre_en  = cfg_q.pre_en;
  assign rd_fast_en = cfg_q.fast_en;
  assign rd_clr_en  = cfg_q.clr_en;
  assign rd_cmp     = cmp_act;

endmodule

// File: rtl/tmr_oc_channel_chk.sv
module tmr_oc_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             chan_en,
  input logic [1:0]       prot_lvl,
  input logic             ext_clr,
  input logic             wr_dir,
  input logic             wr_cfg,
  input logic             wr_cmp,
  input logic [CNT_W-1:0] cmp_wdata,
  input logic             oc_ref,
  input logic [1:0]       rd_dir,
  input logic [2:0]       rd_mode,
  input logic             rd_pre_en,
  input logic             rd_clr_en,
  input logic [CNT_W-1:0] rd_cmp
);

  logic clr_hit;
  assign clr_hit = rd_clr_en & ext_clr;

  p_input_hold_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_dir != 2'b00) |=> $stable(oc_ref));

  p_dir_lock_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_dir && chan_en) |=> $stable(rd_dir));

  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_dir == 2'b00 && rd_mode == 3'b000 && !clr_hit) |=> $stable(oc_ref));

  p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_dir == 2'b00 && rd_mode == 3'b100) |=> !oc_ref);

  p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_dir == 2'b00 && rd_mode == 3'b101 && !clr_hit) |=> oc_ref);

  p_imm_load_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_cmp && !rd_pre_en) |=> (rd_cmp == $past(cmp_wdata)));

  p_ext_clear_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_dir == 2'b00 && clr_hit) |=> !oc_ref);

  p_prot_lock_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_cfg && prot_lvl == 2'b11 && rd_dir == 2'b00) |=> ($stable(rd_mode) && $stable(rd_pre_en)));

endmodule

bind tmr_oc_channel tmr_oc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .chan_en   (chan_en),
  .prot_lvl  (prot_lvl),
  .ext_clr   (ext_clr),
  .wr_dir    (wr_dir),
  .wr_cfg    (wr_cfg),
  .wr_cmp    (wr_cmp),
  .cmp_wdata (cmp_wdata),
  .oc_ref    (oc_ref),
  .rd_dir    (rd_dir),
  .rd_mode   (rd_mode),
  .rd_pre_en (rd_pre_en),
  .rd_clr_en (rd_clr_en),
  .rd_cmp    (rd_cmp)
);

// File: tb/sim_tmr_oc_channel.sv
`timescale 1ns/1ps
module sim_tmr_oc_channel;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cnt_val;
  logic          upd_evt, trig_pulse, ext_clr, chan_en;
  logic [1:0]    prot_lvl;
  logic          wr_dir;
  logic [1:0]    dir_wdata;
  logic          wr_cfg;
  logic [2:0]    cfg_mode;
  logic          cfg_pre_en, cfg_fast_en, cfg_clr_en;
  logic          wr_cmp;
  logic [CW-1:0] cmp_wdata;
  logic          oc_ref;
  logic [1:0]    rd_dir;
  logic [2:0]    rd_mode;
  logic          rd_pre_en, rd_fast_en, rd_clr_en;
  logic [CW-1:0] rd_cmp;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic          m_ref, m_pre, m_fast, m_clr;
  logic [1:0]    m_dir;
  logic [2:0]    m_mode;
  logic [CW-1:0] m_cpre, m_cact;

  always #10 clk = ~clk;

  tmr_oc_channel #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .upd_evt(upd_evt),
    .trig_pulse(trig_pulse), .ext_clr(ext_clr), .chan_en(chan_en),
    .prot_lvl(prot_lvl), .wr_dir(wr_dir), .dir_wdata(dir_wdata),
    .wr_cfg(wr_cfg), .cfg_mode(cfg_mode), .cfg_pre_en(cfg_pre_en),
    .cfg_fast_en(cfg_fast_en), .cfg_clr_en(cfg_clr_en), .wr_cmp(wr_cmp),
    .cmp_wdata(cmp_wdata), .oc_ref(oc_ref), .rd_dir(rd_dir),
    .rd_mode(rd_mode), .rd_pre_en(rd_pre_en), .rd_fast_en(rd_fast_en),
    .rd_clr_en(rd_clr_en), .rd_cmp(rd_cmp)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string ref_req(input logic [1:0] d, input logic [2:0] m,
                                    input logic clrhit);
    if (d != 2'b00) return "R1";
    if (clrhit) return "R9";
    case (m)
      3'b000:                 return "R3";
      3'b001, 3'b010, 3'b011: return "R4";
      3'b100, 3'b101:         return "R5";
      default:                return "R6";
    endcase
  endfunction

  // expected next state from the requirements
  task automatic model_step();
    logic hit, nref;
    logic [1:0] o_dir = m_dir;
    logic [2:0] o_mode = m_mode;
    logic o_pre = m_pre;
    logic [CW-1:0] o_cpre = m_cpre;
    nref = m_ref;
    if (o_dir == 2'b00) begin
      hit = (cnt_val == m_cact) || (m_fast && trig_pulse);
      case (o_mode)
        3'b001: if (hit) nref = 1'b1;
        3'b010: if (hit) nref = 1'b0;
        3'b011: if (hit) nref = ~m_ref;
        3'b100: nref = 1'b0;
        3'b101: nref = 1'b1;
        3'b110: nref = (cnt_val < m_cact);
        3'b111: nref = (cnt_val > m_cact);
        default: nref = m_ref;
      endcase
      if (m_clr && ext_clr) nref = 1'b0;
    end
    m_ref = nref;
    if (wr_dir && !chan_en) m_dir = dir_wdata;
    if (wr_cfg) begin
      m_fast = cfg_fast_en;
      m_clr  = cfg_clr_en;
      if (!(prot_lvl == 2'b11 && o_dir == 2'b00)) begin
        m_mode = cfg_mode;
        m_pre  = cfg_pre_en;
      end
    end
    if (o_pre && upd_evt) m_cact = o_cpre;
    if (!o_pre && wr_cmp) m_cact = cmp_wdata;
    if (wr_cmp) m_cpre = cmp_wdata;
  endtask

  task automatic cyc();
    string rq = ref_req(m_dir, m_mode, m_clr && ext_clr);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(rq,    "oc_ref",  32'(oc_ref),     32'(m_ref));
    chk("R2",  "rd_dir",  32'(rd_dir),     32'(m_dir));
    chk("R10", "rd_mode", 32'(rd_mode),    32'(m_mode));
    chk("R10", "pre_en",  32'(rd_pre_en),  32'(m_pre));
    chk("R10", "fast_en", 32'(rd_fast_en), 32'(m_fast));
    chk("R9",  "clr_en",  32'(rd_clr_en),  32'(m_clr));
    chk("R8",  "rd_cmp",  32'(rd_cmp),     32'(m_cact));
    wr_dir = 0; wr_cfg = 0; wr_cmp = 0; upd_evt = 0; trig_pulse = 0;
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic p, input logic f,
                         input logic c);
    wr_cfg = 1; cfg_mode = m; cfg_pre_en = p; cfg_fast_en = f; cfg_clr_en = c;
    cyc();
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; cnt_val = 0; upd_evt = 0; trig_pulse = 0; ext_clr = 0;
    chan_en = 0; prot_lvl = 0; wr_dir = 0; dir_wdata = 0; wr_cfg = 0;
    cfg_mode = 0; cfg_pre_en = 0; cfg_fast_en = 0; cfg_clr_en = 0;
    wr_cmp = 0; cmp_wdata = 0;
    m_ref = 0; m_pre = 0; m_fast = 0; m_clr = 0; m_dir = 0; m_mode = 0;
    m_cpre = 0; m_cact = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset values, idle through synchronizer release
    chk("R12", "oc_ref", 32'(oc_ref), 0);
    chk("R12", "rd_cmp", 32'(rd_cmp), 0);
    chk("R12", "rd_mode", 32'(rd_mode), 0);
    repeat (3) cyc();

    // R7: immediate compare load
    wr_cmp = 1; cmp_wdata = 16'd5; cyc();
    chk("R7", "rd_cmp literal", 32'(rd_cmp), 5);

    // R4: set on match
    set_cfg(3'b001, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin cnt_val = 16'(i); cyc(); end
    chk("R4", "set literal", 32'(oc_ref), 1);
    set_cfg(3'b010, 0, 0, 0);
    for (int i = 3; i < 7; i++) begin cnt_val = 16'(i); cyc(); end
    chk("R4", "clear literal", 32'(oc_ref), 0);
    set_cfg(3'b011, 0, 0, 0);
    cnt_val = 5; cyc(); cyc(); cyc();
    chk("R4", "toggle x3 literal", 32'(oc_ref), 1);

    // R5: force codes
    cnt_val = 9;
    set_cfg(3'b100, 0, 0, 0); cyc();
    chk("R5", "force low", 32'(oc_ref), 0);
    set_cfg(3'b101, 0, 0, 0); cyc();
    chk("R5", "force high", 32'(oc_ref), 1);

    // R6: freeze then PWM without a match
    set_cfg(3'b000, 0, 0, 0); cyc();
    chk("R3", "freeze holds", 32'(oc_ref), 1);
    set_cfg(3'b110, 0, 0, 0); cyc();
    chk("R6", "pwm1 cnt>cmp", 32'(oc_ref), 0);
    cnt_val = 2; cyc();
    chk("R6", "pwm1 cnt<cmp", 32'(oc_ref), 1);
    set_cfg(3'b111, 0, 0, 0); cyc();
    chk("R6", "pwm2 cnt<cmp", 32'(oc_ref), 0);

    // R8: preload path, write together with update
    set_cfg(3'b000, 1, 0, 0);
    wr_cmp = 1; cmp_wdata = 16'd9; cyc();
    chk("R8", "held in preload", 32'(rd_cmp), 5);
    upd_evt = 1; cyc();
    chk("R8", "moved on update", 32'(rd_cmp), 9);
    wr_cmp = 1; cmp_wdata = 16'd11; cyc();
    wr_cmp = 1; cmp_wdata = 16'd3; upd_evt = 1; cyc();
    chk("R8", "update takes old preload", 32'(rd_cmp), 11);
    upd_evt = 1; cyc();
    chk("R8", "next update", 32'(rd_cmp), 3);

    // R9: clear against set-on-match in the same cycle
    set_cfg(3'b001, 0, 0, 1);
    cnt_val = 3; ext_clr = 1; cyc();
    chk("R9", "clear beats match", 32'(oc_ref), 0);
    ext_clr = 0; cyc();
    chk("R4", "set after clear", 32'(oc_ref), 1);
    set_cfg(3'b101, 0, 0, 0);
    ext_clr = 1; cyc(); cyc();
    chk("R9", "clear disabled", 32'(oc_ref), 1);
    ext_clr = 0;

    // R10: protection lock
    prot_lvl = 2'b11;
    set_cfg(3'b100, 1, 1, 1);
    chk("R10", "mode locked", 32'(rd_mode), 5);
    chk("R10", "fast written", 32'(rd_fast_en), 1);
    prot_lvl = 2'b00;

    // R11: trigger acts as match
    set_cfg(3'b010, 0, 1, 0);
    cnt_val = 0; trig_pulse = 1; cyc();
    chk("R11", "fast trigger clears", 32'(oc_ref), 0);
    set_cfg(3'b001, 0, 0, 0);
    trig_pulse = 1; cyc(); cyc();
    chk("R11", "trigger ignored", 32'(oc_ref), 0);

    // R1 / R2: input role and role lock
    wr_dir = 1; dir_wdata = 2'b01; cyc();
    set_cfg(3'b101, 0, 0, 0); cyc(); cyc();
    chk("R1", "input role holds", 32'(oc_ref), 0);
    chan_en = 1; wr_dir = 1; dir_wdata = 2'b00; cyc();
    chk("R2", "role locked", 32'(rd_dir), 1);
    chan_en = 0; wr_dir = 1; dir_wdata = 2'b00; cyc(); cyc();
    chk("R1", "output again", 32'(oc_ref), 1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      cnt_val    = ($urandom % 8 == 0) ? 16'($urandom % 16) : 16'((cnt_val + 1) % 16);
      upd_evt    = ($urandom % 10 == 0);
      trig_pulse = ($urandom % 16 == 0);
      ext_clr    = ($urandom % 10 == 0);
      chan_en    = $urandom % 2;
      prot_lvl   = 2'($urandom);
      wr_dir     = ($urandom % 30 == 0);
      dir_wdata  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      wr_cfg     = ($urandom % 10 == 0);
      cfg_mode   = 3'($urandom);
      cfg_pre_en = $urandom % 2; cfg_fast_en = $urandom % 2; cfg_clr_en = $urandom % 2;
      wr_cmp     = ($urandom % 10 == 0);
      cmp_wdata  = 16'($urandom % 16);
      cyc();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule